// File: doc/BRIEF.md
# Transmit Parity Error Monitor

This block sits beside the transmitter of a frame-based serial link. It infers receiver-side parity errors from the handshake that comes back. After every frame the transmitter opens a programmable window and waits for the receiver's ready signal. If ready arrives inside the window, the frame counts as good. If it does not, the frame counts as a parity error condition.

The block keeps three pieces of status:
- a sticky flag that gives the outcome of the latest frame;
- a 4-bit tolerance counter that counts down once per error condition;
- a sticky interrupt status bit.

Each error condition that arrives when the tolerance counter is at one or zero fires a single-cycle event. When the counter is loaded with zero, every error fires an event. Software reaches the block through a small write port. Through it software sets the window length, reloads the tolerance counter and clears the sticky bits by writing ones.

Top module: `tx_parity_monitor`

Register selector (`wr_addr_i`):
- 0: window delay, taken from all data bits.
- 1: tolerance counter load, taken from data bits [3:0].
- 2: clear register. Bit 0 clears the error flag and bit 1 clears the interrupt status.
- 3: no register.

## Requirements
- R1: After reset, the error flag, the interrupt status and the event output are 0, the tolerance counter is 3 and the window delay is 3.
- R2: A frame-done strobe seen at clock edge E while idle opens a window. Ready is sampled at edges E+1 through E+1+delay. Ready high at any of these edges closes the window as a good frame, and no event is raised.
- R3: If ready is low at all window edges, an error condition occurs at edge E+1+delay. The error flag is 1 after that edge.
- R4: A good frame clears the error flag at the edge where ready is sampled high.
- R5: Writing selector 2 with bit 0 set clears the error flag. If an error condition occurs in the same cycle, the flag ends up set.
- R6: Each error condition lowers a nonzero tolerance counter by one. At zero the counter stays at zero and never wraps.
- R7: An error condition fires `event_o` for exactly one cycle, after the same edge, only when the counter was 1 or 0 before the condition.
- R8: The interrupt status is set at the same edge as each event and stays set. Writing selector 2 with bit 1 set clears it, but a simultaneous event keeps it set.
- R9: Writing selector 1 loads data bits [3:0] into the tolerance counter. A load in the same cycle as an error condition takes precedence over the decrement. The event decision still uses the value held before the load.
- R10: A frame-done strobe that arrives while a window is open is ignored. It neither restarts nor lengthens the window.
- R11: Writing selector 0 sets the window delay. Writing selector 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_done_i | input | 1 | One-cycle strobe at the end of a transmitted frame |
| ready_i | input | 1 | Receiver ready handshake, sampled each clock |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register selector |
| wr_data_i | input | 8 | Write data |
| err_flag_o | output | 1 | Sticky parity error flag for the latest frame |
| irq_status_o | output | 1 | Sticky interrupt status |
| event_o | output | 1 | Single-cycle parity error event |
| tol_cnt_o | output | 4 | Remaining tolerance count |

## Verification
Two kinds of collision can land in the same cycle. The first is the timeout of a window, which sets the flag, counts down and may fire an event. The second is a software write to the flag clear, to the interrupt clear or to the tolerance reload. The bench provokes each collision by driving the write on exactly the cycle whose closing edge ends the window without ready. It then judges the result against the priorities in R5, R8 and R9: the flag stays set, the interrupt stays set, and the reloaded value replaces the decrement while the event still follows the old count.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

    typedef enum logic [1:0] {
        SEL_DELAY = 2'd0,
        SEL_TOL   = 2'd1,
        SEL_CLEAR = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    localparam int CLR_ERR_BIT = 0;
    localparam int CLR_IRQ_BIT = 1;

endpackage

// File: rtl/tpm_regs.sv
module tpm_regs
    import tpm_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 8,
    parameter int DELAY_W   = 8,
    parameter int CNT_W     = 4,
    parameter int RST_DELAY = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [DELAY_W-1:0] delay_o,
    output logic               tol_load_o,
    output logic [CNT_W-1:0]   tol_val_o,
    output logic               clr_err_o,
    output logic               clr_irq_o
);

    typedef struct packed {
        logic [DELAY_W-1:0] delay;
    } regs_t;

    regs_t    r_q, r_d;
    reg_sel_e sel;

    assign sel = reg_sel_e'(wr_addr_i);

    always_comb begin
        r_d        = r_q;
        tol_load_o = 1'b0;
        clr_err_o  = 1'b0;
        clr_irq_o  = 1'b0;
        if (wr_en_i) begin
            unique case (sel)
                SEL_DELAY: r_d.delay  = wr_data_i[DELAY_W-1:0];
                SEL_TOL:   tol_load_o = 1'b1;
                SEL_CLEAR: begin
                    clr_err_o = wr_data_i[CLR_ERR_BIT];
                    clr_irq_o = wr_data_i[CLR_IRQ_BIT];
                end
                default: ;
            endcase
        end
    end

    assign tol_val_o = wr_data_i[CNT_W-1:0];
    assign delay_o   = r_q.delay;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{delay: DELAY_W'(RST_DELAY)};
        else         r_q <= r_d;
    end

    AST_DELAY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && wr_addr_i == SEL_DELAY) |=> delay_o == $past(delay_o)); // R11

endmodule

// File: rtl/tpm_window.sv
module tpm_window #(
    parameter int DELAY_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic               ready_i,
    input  logic [DELAY_W-1:0] delay_i,
    output logic               ok_o,
    output logic               tmo_o,
    output logic               busy_o
);

    typedef struct packed {
        logic               busy;
        logic [DELAY_W-1:0] cnt;
    } win_t;

    win_t w_q, w_d;

    always_comb begin
        w_d   = w_q;
        ok_o  = w_q.busy && ready_i;
        tmo_o = w_q.busy && !ready_i && (w_q.cnt >= delay_i);
        if (!w_q.busy) begin
            if (start_i) begin
                w_d.busy = 1'b1;
                w_d.cnt  = '0;
            end
        end else if (ok_o || tmo_o) begin
            w_d.busy = 1'b0;
            w_d.cnt  = '0;
        end else begin
            w_d.cnt = w_q.cnt + 1'b1;
        end
    end

    assign busy_o = w_q.busy;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) w_q <= '0;
        else         w_q <= w_d;
    end

    AST_WIN_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ok_o || tmo_o) |=> !busy_o); // R2

    AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i && !ok_o && !tmo_o) |=> (busy_o && w_q.cnt != '0)); // R10

endmodule

// File: rtl/tpm_tolerance.sv
module tpm_tolerance #(
    parameter int CNT_W   = 4,
    parameter int RST_TOL = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             err_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             evt_trig_o,
    output logic             event_o,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             evt;
    } tol_t;

    tol_t t_q, t_d;

    always_comb begin
        t_d        = t_q;
        evt_trig_o = err_i && (t_q.cnt <= CNT_W'(1));
        t_d.evt    = evt_trig_o;
        if (load_i)                       t_d.cnt = load_val_i;
        else if (err_i && t_q.cnt != '0)  t_d.cnt = t_q.cnt - 1'b1;
    end

    assign cnt_o   = t_q.cnt;
    assign event_o = t_q.evt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) t_q <= '{cnt: CNT_W'(RST_TOL), evt: 1'b0};
        else         t_q <= t_d;
    end

    AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && cnt_o == '0) |=> cnt_o == '0); // R6

    AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_i && !load_i && cnt_o != '0) |=> cnt_o == CNT_W'($past(cnt_o) - 1'b1)); // R6

    AST_EVT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        event_o |=> !event_o); // R7

    AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> cnt_o == $past(load_val_i)); // R9

endmodule

// File: rtl/tpm_flags.sv
module tpm_flags (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tmo_i,
    input  logic ok_i,
    input  logic clr_err_i,
    input  logic evt_trig_i,
    input  logic clr_irq_i,
    output logic err_o,
    output logic irq_o
);

    typedef struct packed {
        logic err;
        logic irq;
    } flg_t;

    flg_t f_q, f_d;

    always_comb begin
        f_d = f_q;
        if (ok_i || clr_err_i) f_d.err = 1'b0;
        if (tmo_i)             f_d.err = 1'b1;
        if (clr_irq_i)         f_d.irq = 1'b0;
        if (evt_trig_i)        f_d.irq = 1'b1;
    end

    assign err_o = f_q.err;
    assign irq_o = f_q.irq;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) f_q <= '0;
        else         f_q <= f_d;
    end

    AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmo_i |=> err_o); // R3

    AST_ERR_OK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ok_i && !tmo_i) |=> !err_o); // R4

    AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !clr_irq_i) |=> irq_o); // R8

endmodule

// File: rtl/tx_parity_monitor.sv
module tx_parity_monitor #(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 4,
    parameter int RST_DELAY = 3,
    parameter int RST_TOL   = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              frame_done_i,
    input  logic              ready_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              err_flag_o,
    output logic              irq_status_o,
    output logic              event_o,
    output logic [CNT_W-1:0]  tol_cnt_o
);

    localparam int DELAY_W = DATA_W;

    logic [DELAY_W-1:0] delay;
    logic               tol_load;
    logic [CNT_W-1:0]   tol_val;
    logic               clr_err, clr_irq;
    logic               ok, tmo, busy, evt_trig;

    tpm_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DELAY_W(DELAY_W),
        .CNT_W(CNT_W), .RST_DELAY(RST_DELAY)
    ) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .delay_o(delay), .tol_load_o(tol_load), .tol_val_o(tol_val),
        .clr_err_o(clr_err), .clr_irq_o(clr_irq)
    );

    tpm_window #(.DELAY_W(DELAY_W)) u_win (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .start_i(frame_done_i), .ready_i(ready_i), .delay_i(delay),
        .ok_o(ok), .tmo_o(tmo), .busy_o(busy)
    );

    tpm_tolerance #(.CNT_W(CNT_W), .RST_TOL(RST_TOL)) u_tol (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .err_i(tmo), .load_i(tol_load), .load_val_i(tol_val),
        .evt_trig_o(evt_trig), .event_o(event_o), .cnt_o(tol_cnt_o)
    );

    tpm_flags u_flg (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .tmo_i(tmo), .ok_i(ok), .clr_err_i(clr_err),
        .evt_trig_i(evt_trig), .clr_irq_i(clr_irq),
        .err_o(err_flag_o), .irq_o(irq_status_o)
    );

    AST_EVT_WITH_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        event_o |-> irq_status_o); // R8

    AST_EVT_NEEDS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        event_o |-> err_flag_o || $past(clr_err)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy |=> !event_o); // R2

endmodule

// File: tb/sim_tx_parity_monitor.sv
`timescale 1ns/1ps
module sim_tx_parity_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_done = 1'b0, ready = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       err, irq, evt;
    logic [3:0] tol;

    int n_chk = 0, n_fail = 0;
    int m_delay = 3, m_tol = 3;
    bit m_err = 0, m_irq = 0;

    always #2.5 clk = ~clk;

    tx_parity_monitor u0 (
        .clk_i(clk), .rst_ni(rst_n), .frame_done_i(frame_done), .ready_i(ready),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .err_flag_o(err), .irq_status_o(irq), .event_o(evt), .tol_cnt_o(tol)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_all(input string req);
        check({req, " err"}, int'(err), int'(m_err));
        check({req, " irq"}, int'(irq), int'(m_irq));
        check({req, " tol"}, int'(tol), m_tol);
    endtask

    // coll: 0 none, 1 clear err, 2 clear irq, 3 load tolerance with ld
    task automatic run_frame(input int off, input bit mid_start, input int coll, input int ld);
        bit fire;
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        for (int k = 0; k <= m_delay; k++) begin
            bit tmo_here;
            tmo_here = (k == m_delay) && (k != off);
            ready = (k == off);
            if (mid_start && k == 1) frame_done = 1'b1;
            if (tmo_here && coll != 0) begin
                wr_en = 1'b1;
                wr_addr = (coll == 3) ? 2'd1 : 2'd2;
                wr_data = (coll == 3) ? 8'(ld) : ((coll == 1) ? 8'd1 : 8'd2);
            end
            @(negedge clk);
            frame_done = 1'b0; ready = 1'b0; wr_en = 1'b0;
            if (k == off) begin
                m_err = 0;
                check("R4 good frame clears flag", int'(err), 0);
                check("R2 no event on good frame", int'(evt), 0);
                break;
            end else if (tmo_here) begin
                fire = (m_tol <= 1);
                if (coll == 3) m_tol = ld;
                else if (m_tol > 0) m_tol--;
                m_err = 1;
                if (fire) m_irq = 1;
                check("R3 timeout sets flag", int'(err), 1);
                check("R7 event decision", int'(evt), int'(fire));
                check("R6/R9 tolerance count", int'(tol), m_tol);
                check("R8 irq status", int'(irq), int'(m_irq));
                @(negedge clk);
                check("R7 event one cycle", int'(evt), 0);
            end else begin
                check("R2 no event inside window", int'(evt), 0);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 err", int'(err), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 event", int'(evt), 0);
        check("R1 tol", int'(tol), 3);
        // R1 reset delay of 3: no ready, timeout at fourth edge
        run_frame(4, 0, 0, 0);

        // Sweep: tolerance 0..3, delay 0..3, ready offset 0..delay+1 (last = never)
        for (int t = 0; t < 4; t++) begin
            for (int d = 0; d < 4; d++) begin
                for (int off = 0; off <= d + 1; off++) begin
                    wr(2'd1, 8'(t)); m_tol = t;
                    wr(2'd0, 8'(d)); m_delay = d;
                    wr(2'd2, 8'd2);  m_irq = 0;
                    check_all("R8/R9 after writes");
                    run_frame(off, 0, 0, 0);
                end
            end
        end

        // R6 saturation: repeated errors at zero
        wr(2'd1, 8'd0); m_tol = 0;
        for (int i = 0; i < 3; i++) run_frame(m_delay + 1, 0, 0, 0);
        check_all("R6 saturated");

        // R5 software clear of error flag
        wr(2'd2, 8'd1); m_err = 0;
        check("R5 software clear", int'(err), 0);

        // R10 frame-done during open window is ignored
        wr(2'd0, 8'd3); m_delay = 3;
        wr(2'd1, 8'd5); m_tol = 5;
        run_frame(0, 0, 0, 0);
        run_frame(4, 1, 0, 0);
        @(negedge clk);
        check("R10 window not restarted", int'(evt), 0);
        check_all("R10 state");

        // Collisions at the timeout cycle
        run_frame(0, 0, 0, 0);
        run_frame(4, 0, 1, 0);          // R5 set wins over clear
        wr(2'd1, 8'd1); m_tol = 1;
        run_frame(4, 0, 2, 0);          // R8 event wins over irq clear
        wr(2'd1, 8'd2); m_tol = 2;
        run_frame(4, 0, 3, 9);          // R9 load wins, no event
        wr(2'd1, 8'd1); m_tol = 1;
        run_frame(4, 0, 3, 5);          // R9 load wins, event from old count

        // R11 selector 3 writes nothing; selector 0 sets delay
        wr(2'd0, 8'd2); m_delay = 2;
        wr(2'd3, 8'hFF);
        check_all("R11 selector 3 no effect");
        run_frame(3, 0, 0, 0);
        run_frame(1, 0, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule